// File: doc/BRIEF.md
# Sensor-Node Module Clock-Gating Controller

This controller decides, cycle by cycle, which of the four modules of a small sensor node receive a clock. The four modules are the processor, the data-acquisition unit, the radio transmitter and the radio receiver. A phase state machine steps through idle, acquire, process, transmit and receive. A fixed table turns each phase into one enable per module. Each enable feeds the clock gate of its module. The modules, the radio protocol and the gate cells sit outside this block.

The inputs are three request pins, for sampling, sending and listening, and one done pin per module. Requests may be single-cycle pulses. A request that arrives while the node is busy is held until it is served. The controller has no data path. Every pin is a plain control level or strobe, so there is no valid/ready handshake and no back-pressure.

When the controller enters a phase, it first raises the enable of the module that does the work. One cycle later it pulses that module's start strobe, so the module already has a running clock when it is told to begin. The phase is also driven out as a code for observation.

Top module: `node_clkgate_ctrl`

## Requirements
- R1: While reset is held and after its release with no stimulus, every enable and every start strobe is 0 and the phase code is 0 (idle).
- R2: In the acquire phase (code 1), the processor and acquisition enables are 1, and the transmitter and receiver enables are 0.
- R3: In the process phase (code 2), only the processor enable is 1.
- R4: In the transmit phase (code 3), the processor and transmitter enables are 1, and the other two are 0.
- R5: In the receive phase (code 4), the processor and receiver enables are 1, and the other two are 0.
- R6: In idle (code 0), all four enables are 0.
- R7: When idle, the controller serves pending requests in this priority order: listen (goes to receive), then send (goes to transmit), then sample (goes to acquire). A request pulse seen in any phase stays pending until the controller serves it.
- R8: Phase changes on a done strobe are as follows:
  - acquisition done moves the controller to process;
  - processor done moves it to transmit if a send request is pending or arrives in the same cycle, and to idle otherwise;
  - transmitter done and receiver done each return it to idle.
- R9: Enables and the phase code are registered and change one clock edge after the deciding input. When a phase is entered, its working module's start strobe pulses for exactly one cycle, in the cycle after the enable rose. At most one start strobe is high at any time.
- R10: A done strobe is ignored, and the phase code and enables stay unchanged, in two cases: when it belongs to a module whose phase is not active, and when it arrives in the first cycle of a phase, before that phase's start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (never gated) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_req | input | 1 | Request to acquire a sample |
| send_req | input | 1 | Request to transmit |
| listen_req | input | 1 | Request to receive |
| acq_done | input | 1 | Acquisition unit finished |
| proc_done | input | 1 | Processor finished its processing step |
| tx_done | input | 1 | Transmitter finished |
| rx_done | input | 1 | Receiver finished |
| en_cpu | output | 1 | Clock enable for the processor |
| en_daq | output | 1 | Clock enable for the acquisition unit |
| en_tx | output | 1 | Clock enable for the transmitter |
| en_rx | output | 1 | Clock enable for the receiver |
| start_acq | output | 1 | One-cycle start pulse to the acquisition unit |
| start_proc | output | 1 | One-cycle start pulse to the processor |
| start_tx | output | 1 | One-cycle start pulse to the transmitter |
| start_rx | output | 1 | One-cycle start pulse to the receiver |
| phase_o | output | 3 | Current phase code (0 idle, 1 acquire, 2 process, 3 transmit, 4 receive) |

## Verification
Two functions can fall in the same cycle: a phase-exit done strobe and the arrival of a new request. The key case is processor done together with a send pulse, which must go straight to transmit. A second case is a listen request that lands while the controller is leaving transmit. The bench forces these collisions directly, alongside random request and done traffic. It judges every cycle against a phase model that treats a same-cycle request as already pending. It also fires done strobes in the first cycle of a phase and confirms, through the phase code and enables, that they were ignored.

// File: rtl/node_cg_pkg.sv
package node_cg_pkg;
  localparam int N_MOD = 4;
  localparam int N_REQ = 3;
  localparam int PH_W  = 3;

  localparam int M_CPU = 0;
  localparam int M_DAQ = 1;
  localparam int M_TX  = 2;
  localparam int M_RX  = 3;

  localparam int Q_SAMPLE = 0;
  localparam int Q_SEND   = 1;
  localparam int Q_LISTEN = 2;

  // done/start vectors are indexed by work phase: acquire, process, transmit, receive
  localparam int W_ACQ  = 0;
  localparam int W_PROC = 1;
  localparam int W_TX   = 2;
  localparam int W_RX   = 3;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE = 3'd0,
    PH_ACQ  = 3'd1,
    PH_PROC = 3'd2,
    PH_TX   = 3'd3,
    PH_RX   = 3'd4
  } phase_e;

  function automatic logic [N_MOD-1:0] en_table(input phase_e ph);
    logic [N_MOD-1:0] v;
    v = '0;
    case (ph)
      PH_ACQ:  begin v[M_CPU] = 1'b1; v[M_DAQ] = 1'b1; end
      PH_PROC: begin v[M_CPU] = 1'b1; end
      PH_TX:   begin v[M_CPU] = 1'b1; v[M_TX]  = 1'b1; end
      PH_RX:   begin v[M_CPU] = 1'b1; v[M_RX]  = 1'b1; end
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/node_req_pend.sv
module node_req_pend
  import node_cg_pkg::*;
#(
  parameter int NQ = N_REQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] req_i,
  input  logic [NQ-1:0] grant_i,
  output logic [NQ-1:0] eff_o
);
  logic [NQ-1:0] pend_q;

  assign eff_o = pend_q | req_i;

  for (genvar i = 0; i < NQ; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= eff_o[i] & ~grant_i[i];
    end
  end
endmodule

// File: rtl/node_phase_fsm.sv
module node_phase_fsm
  import node_cg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] eff_i,
  input  logic [N_MOD-1:0] done_i,
  output logic [N_REQ-1:0] grant_o,
  output phase_e           phase_q,
  output phase_e           phase_nx,
  output logic [N_MOD-1:0] start_q
);
  logic             arm_q, arm_nx;
  logic [N_MOD-1:0] start_nx;

  always_comb begin
    phase_nx = phase_q;
    grant_o  = '0;
    case (phase_q)
      PH_IDLE: begin
        if (eff_i[Q_LISTEN]) begin
          phase_nx = PH_RX; grant_o[Q_LISTEN] = 1'b1;
        end else if (eff_i[Q_SEND]) begin
          phase_nx = PH_TX; grant_o[Q_SEND] = 1'b1;
        end else if (eff_i[Q_SAMPLE]) begin
          phase_nx = PH_ACQ; grant_o[Q_SAMPLE] = 1'b1;
        end
      end
      PH_ACQ:  if (!arm_q && done_i[W_ACQ]) phase_nx = PH_PROC;
      PH_PROC: if (!arm_q && done_i[W_PROC]) begin
        if (eff_i[Q_SEND]) begin
          phase_nx = PH_TX; grant_o[Q_SEND] = 1'b1;
        end else begin
          phase_nx = PH_IDLE;
        end
      end
      PH_TX:   if (!arm_q && done_i[W_TX]) phase_nx = PH_IDLE;
      PH_RX:   if (!arm_q && done_i[W_RX]) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  assign arm_nx = (phase_nx != phase_q) && (phase_nx != PH_IDLE);

  always_comb begin
    for (int k = 0; k < N_MOD; k++)
      start_nx[k] = arm_q && (phase_q == phase_e'(PH_W'(k + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      arm_q   <= 1'b0;
      start_q <= '0;
    end else begin
      phase_q <= phase_nx;
      arm_q   <= arm_nx;
      start_q <= start_nx;
    end
  end
endmodule

// File: rtl/node_en_reg.sv
module node_en_reg
  import node_cg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_nx,
  output logic [N_MOD-1:0] en_q
);
  logic [N_MOD-1:0] en_nx;

  assign en_nx = en_table(phase_nx);

  for (genvar m = 0; m < N_MOD; m++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[m] <= 1'b0;
      else        en_q[m] <= en_nx[m];
    end
  end
endmodule

// File: rtl/node_clkgate_ctrl.sv
module node_clkgate_ctrl
  import node_cg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_req,
  input  logic            send_req,
  input  logic            listen_req,
  input  logic            acq_done,
  input  logic            proc_done,
  input  logic            tx_done,
  input  logic            rx_done,
  output logic            en_cpu,
  output logic            en_daq,
  output logic            en_tx,
  output logic            en_rx,
  output logic            start_acq,
  output logic            start_proc,
  output logic            start_tx,
  output logic            start_rx,
  output logic [PH_W-1:0] phase_o
);
  logic [N_REQ-1:0] req_v, eff_v, grant_v;
  logic [N_MOD-1:0] done_v, start_v, en_v;
  phase_e           ph_q, ph_nx;

  assign req_v  = {listen_req, send_req, sample_req};
  assign done_v = {rx_done, tx_done, proc_done, acq_done};

  node_req_pend #(.NQ(N_REQ)) pend_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_v), .grant_i(grant_v), .eff_o(eff_v)
  );

  node_phase_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .eff_i(eff_v), .done_i(done_v),
    .grant_o(grant_v), .phase_q(ph_q), .phase_nx(ph_nx), .start_q(start_v)
  );

  node_en_reg en_i (
    .clk(clk), .rst_n(rst_n), .phase_nx(ph_nx), .en_q(en_v)
  );

  assign en_cpu     = en_v[M_CPU];
  assign en_daq     = en_v[M_DAQ];
  assign en_tx      = en_v[M_TX];
  assign en_rx      = en_v[M_RX];
  assign start_acq  = start_v[W_ACQ];
  assign start_proc = start_v[W_PROC];
  assign start_tx   = start_v[W_TX];
  assign start_rx   = start_v[W_RX];
  assign phase_o    = ph_q;
endmodule

// File: rtl/node_cg_chk.sv
module node_cg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_cpu,
  input logic       en_daq,
  input logic       en_tx,
  input logic       en_rx,
  input logic       start_acq,
  input logic       start_proc,
  input logic       start_tx,
  input logic       start_rx,
  input logic [2:0] phase_o
);
  a_r6_idle_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0) |-> !(en_cpu || en_daq || en_tx || en_rx));

  a_r3_proc_cpu_only: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd2) |-> (en_cpu && !en_daq && !en_tx && !en_rx));

  a_r2_acq_units: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1) |-> (en_cpu && en_daq && !en_tx && !en_rx));

  a_r9_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_acq, start_proc, start_tx, start_rx}));

  a_r9_tx_en_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_tx |-> (en_tx && $past(en_tx)));

  a_r9_daq_en_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_acq |-> (en_daq && $past(en_daq)));

  a_r8_acq_exits_to_proc: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 3'd1 && phase_o != 3'd1) |-> (phase_o == 3'd2));

  a_r10_rx_holds_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_rx) |=> (phase_o == 3'd4));
endmodule

bind node_clkgate_ctrl node_cg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_cpu(en_cpu), .en_daq(en_daq), .en_tx(en_tx),
  .en_rx(en_rx), .start_acq(start_acq), .start_proc(start_proc),
  .start_tx(start_tx), .start_rx(start_rx), .phase_o(phase_o)
);

// File: tb/node_clkgate_ctrl_tb.sv
`timescale 1ns/1ps
module node_clkgate_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_req = 0, send_req = 0, listen_req = 0;
  logic acq_done = 0, proc_done = 0, tx_done = 0, rx_done = 0;
  logic en_cpu, en_daq, en_tx, en_rx;
  logic start_acq, start_proc, start_tx, start_rx;
  logic [2:0] phase_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  node_clkgate_ctrl dut_i (.*);

  // reference state
  bit [2:0] m_ph;
  bit       m_arm;
  bit [2:0] m_pend;
  bit [3:0] m_start;

  // returns {rx,tx,daq,cpu}
  function automatic bit [3:0] exp_en(bit [2:0] ph);
    case (ph)
      3'd1: return 4'b0011;
      3'd2: return 4'b0001;
      3'd3: return 4'b0101;
      3'd4: return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string en_tag(bit [2:0] ph);
    case (ph)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic model_step(bit [2:0] req, bit [3:0] dn);
    bit [2:0] eff, g, nx;
    eff = m_pend | req; g = 0; nx = m_ph;
    case (m_ph)
      3'd0: if (eff[2]) begin nx = 4; g[2] = 1; end
            else if (eff[1]) begin nx = 3; g[1] = 1; end
            else if (eff[0]) begin nx = 1; g[0] = 1; end
      3'd1: if (!m_arm && dn[0]) nx = 2;
      3'd2: if (!m_arm && dn[1]) begin
              if (eff[1]) begin nx = 3; g[1] = 1; end else nx = 0;
            end
      3'd3: if (!m_arm && dn[2]) nx = 0;
      3'd4: if (!m_arm && dn[3]) nx = 0;
      default: nx = 0;
    endcase
    m_start = 0;
    if (m_arm && m_ph != 0) m_start[m_ph - 1] = 1'b1;
    m_arm  = (nx != m_ph) && (nx != 0);
    m_pend = eff & ~g;
    m_ph   = nx;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({en_tag(m_ph), " enables"}, {en_rx, en_tx, en_daq, en_cpu}, exp_en(m_ph));
    chk("R9 start strobes", {start_rx, start_tx, start_proc, start_acq}, m_start);
    chk("R7/R8 phase", phase_o, m_ph);
  endtask

  // drive at a negedge, then compare at the following negedge
  task automatic step(bit [2:0] req, bit [3:0] dn);
    {listen_req, send_req, sample_req} = req;
    {rx_done, tx_done, proc_done, acq_done} = dn;
    model_step(req, dn);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_ph = 0; m_arm = 0; m_pend = 0; m_start = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 enables in reset", {en_rx, en_tx, en_daq, en_cpu}, 0);
    chk("R1 starts in reset", {start_rx, start_tx, start_proc, start_acq}, 0);
    chk("R1 phase in reset", phase_o, 0);
    rst_n = 1'b1;
    step(3'b000, 4'b0000);

    // R7: all three requests together -> receive wins
    step(3'b111, 4'b0000);
    chk("R7 listen first", phase_o, 4);
    // R10: rx done in the first cycle of receive is ignored
    step(3'b000, 4'b1000);
    chk("R10 rx done in first cycle", phase_o, 4);
    chk("R10 rx enable kept", en_rx, 1);
    // R10: foreign done is ignored
    step(3'b000, 4'b0111);
    chk("R10 foreign done", phase_o, 4);
    step(3'b000, 4'b1000);
    chk("R8 rx done to idle", phase_o, 0);
    // pending send then sample remain queued (R7)
    step(3'b000, 4'b0000);
    chk("R7 send second", phase_o, 3);
    step(3'b000, 4'b0000);
    step(3'b000, 4'b0100);
    step(3'b000, 4'b0000);
    chk("R7 sample third", phase_o, 1);
    step(3'b000, 4'b0000);
    step(3'b000, 4'b0001);
    chk("R8 acq done to proc", phase_o, 2);
    step(3'b000, 4'b0000);
    // R8: proc done with same-cycle send -> transmit
    step(3'b010, 4'b0010);
    chk("R8 proc done plus send", phase_o, 3);
    step(3'b000, 4'b0000);
    // tx done with same-cycle listen -> idle, then receive
    step(3'b100, 4'b0100);
    chk("R8 tx done to idle", phase_o, 0);
    step(3'b000, 4'b0000);
    chk("R7 held listen served", phase_o, 4);
    step(3'b000, 4'b0000);
    step(3'b000, 4'b1000);
    // R8: proc done with nothing pending -> idle
    step(3'b001, 4'b0000);
    step(3'b000, 4'b0000);
    step(3'b000, 4'b0001);
    step(3'b000, 4'b0000);
    step(3'b000, 4'b0010);
    chk("R8 proc done to idle", phase_o, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit [2:0] rq;
      bit [3:0] dn;
      rq[0] = ($urandom % 100) < 8;
      rq[1] = ($urandom % 100) < 6;
      rq[2] = ($urandom % 100) < 5;
      for (int k = 0; k < 4; k++) dn[k] = ($urandom % 100) < 30;
      step(rq, dn);
    end

    finished = 1;
    finish_run();
  end
endmodule